// File: doc/BRIEF.md
# Dual-Slot Transmit Frame Queue

This block is the device-side transmit controller of a small Ethernet MAC. A host loads frame bytes into an internal circular byte buffer through a data port. It sets a 16-bit byte count through two byte-wide length registers. It then writes a poll command to queue the frame. The queued frame is made of the last N bytes written to the data port, where N is the length register at the moment of the poll.

Up to two frames can wait at once, each held in one of two slots. The slots share the single length register and the single poll command. Frames leave in the order they were queued, over a byte stream with a valid/ready handshake and a last-byte marker.

Each slot has its own sticky completion flag, which the host clears by writing 1 to it. A shared transmit-done interrupt bit also drives an interrupt output. A poll issued while both slots are taken is dropped and recorded in an overrun flag. A readable read pointer shows the buffer address being sent.

Top module: `txdual_ctrl`

## Requirements
- R1: Writing register 0x04 sets bits 7:0 and writing register 0x05 sets bits 15:8 of the 16-bit frame length; both read back the stored byte from the cycle after the write.
- R2: Each write to register 0x08 stores the byte at the buffer write pointer, which then advances by one modulo the buffer depth. A queued frame of length N is the N bytes written just before the poll, and the stream sends them in write order.
- R3: Writing a value with bit 0 set to register 0x02 queues a frame. Bit 0 of register 0x02 reads 1 from the cycle after a queueing poll until the last queued frame has completed.
- R4: The first byte of a frame is presented in the second cycle after the poll edge when the stream is idle. Frames are sent strictly in queue order, with exactly one idle cycle between the last byte of one frame and the first byte of the next queued frame.
- R5: While a frame is sent, the stream presents one byte and advances only on cycles with ready high, holding the byte while ready is low. The last-byte marker is high only on the final byte of each frame.
- R6: Register 0x01 bit 2 is the completion flag of slot 0 and bit 3 that of slot 1. A frame entering an empty queue uses slot 0, and a frame entering a one-frame queue uses the other slot. Each flag is set when its frame's last byte is accepted, stays set, and is cleared by writing 1 to its position; a set in the same cycle wins.
- R7: Register 0x06 bit 1 is set whenever any frame completes, is cleared by writing 1 to it (a set in the same cycle wins), and drives the interrupt output.
- R8: A poll while both slots are occupied queues nothing and sets register 0x01 bit 4, which is cleared by writing 1 to it.
- R9: A poll with a length of zero queues nothing and sends nothing.
- R10: Registers 0x0A (low byte) and 0x0B (high byte) read the buffer read pointer: the address of the byte being presented while sending, and the address after the last sent byte once a frame ends.
- R11: After reset the stream is idle, the interrupt output is low, and every readable register reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 8 | Register address, used for both writes and reads |
| host_wdata | input | 8 | Register write data |
| host_rdata | output | 8 | Combinational read data for host_addr |
| tx_data | output | 8 | Stream byte |
| tx_valid | output | 1 | Stream byte is valid |
| tx_last | output | 1 | Stream byte is the last of its frame |
| tx_ready | input | 1 | Downstream accepts the byte in this cycle |
| tx_irq | output | 1 | Transmit-done interrupt |

## Verification
Register writes show on reads in the cycle after their write edge. The first byte of a frame appears two edges after the poll edge. Completion flags, the interrupt and the advance of the read pointer all take effect at the edge that accepts the byte concerned, and a queued follower starts one cycle after its predecessor ends. The bench keeps a behavioural model that steps at the same edges and compares the stream, the interrupt and the read data of the presented address in the middle of every cycle. Frame counts taken from the ports are also checked after the overrun and zero-length cases.

// File: rtl/txdual_pkg.sv
package txdual_pkg;
   localparam int LEN_W     = 16;
   localparam int NUM_SLOTS = 2;

   localparam logic [7:0] RA_STATUS  = 8'h01;
   localparam logic [7:0] RA_CMD     = 8'h02;
   localparam logic [7:0] RA_LEN_LO  = 8'h04;
   localparam logic [7:0] RA_LEN_HI  = 8'h05;
   localparam logic [7:0] RA_IRQ     = 8'h06;
   localparam logic [7:0] RA_FIFO    = 8'h08;
   localparam logic [7:0] RA_RPTR_LO = 8'h0A;
   localparam logic [7:0] RA_RPTR_HI = 8'h0B;

   localparam int ST_DONE0 = 2;
   localparam int ST_DONE1 = 3;
   localparam int ST_OVR   = 4;
   localparam int IRQ_TX   = 1;
   localparam int CMD_POLL = 0;

   typedef enum logic {SND_IDLE = 1'b0, SND_RUN = 1'b1} snd_state_e;
endpackage

// File: rtl/txdual_buf.sv
module txdual_buf #(
   parameter int DEPTH = 256,
   parameter int AW    = 8
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [7:0]    wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [7:0]    rd_data
);
   logic [7:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem_q[wr_addr] <= wr_data;
   end

   assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/txdual_slots.sv
module txdual_slots
   import txdual_pkg::*;
#(
   parameter int AW = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [AW-1:0]    push_start,
   input  logic [LEN_W-1:0] push_len,
   input  logic             pop,
   output logic             head_valid,
   output logic             head_idx,
   output logic [AW-1:0]    head_start,
   output logic [LEN_W-1:0] head_len,
   output logic             full,
   output logic             any_busy
);
   logic [NUM_SLOTS-1:0] valid_q;
   logic [AW-1:0]        start_q [NUM_SLOTS];
   logic [LEN_W-1:0]     len_q   [NUM_SLOTS];
   logic                 head_q;
   logic                 free_idx;

   // lowest free slot: slot 1 only when slot 0 is taken
   assign free_idx = valid_q[0];
   assign full     = &valid_q;
   assign any_busy = |valid_q;

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_q[i] <= 1'b0;
            start_q[i] <= '0;
            len_q[i]   <= '0;
         end else begin
            if (pop && head_q == 1'(i)) valid_q[i] <= 1'b0;
            if (push && free_idx == 1'(i)) begin
               valid_q[i] <= 1'b1;
               start_q[i] <= push_start;
               len_q[i]   <= push_len;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 head_q <= 1'b0;
      else if (push && !any_busy) head_q <= free_idx;
      else if (pop)               head_q <= ~head_q;
   end

   assign head_idx   = head_q;
   assign head_valid = valid_q[head_q];
   assign head_start = start_q[head_q];
   assign head_len   = len_q[head_q];

   a_r4_pop_from_valid: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> head_valid);
   a_r8_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   a_r4_follower_waits: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && full) |=> head_valid);
endmodule

// File: rtl/txdual_sender.sv
module txdual_sender
   import txdual_pkg::*;
#(
   parameter int AW = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             head_valid,
   input  logic [AW-1:0]    head_start,
   input  logic [LEN_W-1:0] head_len,
   output logic [AW-1:0]    rd_addr,
   input  logic [7:0]       rd_data,
   output logic [7:0]       tx_data,
   output logic             tx_valid,
   output logic             tx_last,
   input  logic             tx_ready,
   output logic             done_pulse
);
   snd_state_e       state_q;
   logic [AW-1:0]    rptr_q;
   logic [LEN_W-1:0] remain_q;

   assign tx_valid   = (state_q == SND_RUN);
   assign tx_last    = tx_valid && (remain_q == LEN_W'(1));
   assign tx_data    = rd_data;
   assign rd_addr    = rptr_q;
   assign done_pulse = tx_valid && tx_ready && tx_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= SND_IDLE;
         rptr_q   <= '0;
         remain_q <= '0;
      end else begin
         unique case (state_q)
            SND_IDLE: if (head_valid) begin
               rptr_q   <= head_start;
               remain_q <= head_len;
               state_q  <= SND_RUN;
            end
            SND_RUN: if (tx_ready) begin
               rptr_q   <= rptr_q + 1'b1;
               remain_q <= remain_q - 1'b1;
               if (remain_q == LEN_W'(1)) state_q <= SND_IDLE;
            end
            default: state_q <= SND_IDLE;
         endcase
      end
   end

   a_r5_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(rd_addr) && $stable(tx_last)));
   a_r5_advance_one: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready && !tx_last) |=> (tx_valid && rd_addr == $past(rd_addr) + 1'b1));
   a_r4_gap_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |=> !tx_valid);
endmodule

// File: rtl/txdual_ctrl.sv
module txdual_ctrl
   import txdual_pkg::*;
#(
   parameter int BUF_DEPTH = 256
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       host_wr,
   input  logic [7:0] host_addr,
   input  logic [7:0] host_wdata,
   output logic [7:0] host_rdata,
   output logic [7:0] tx_data,
   output logic       tx_valid,
   output logic       tx_last,
   input  logic       tx_ready,
   output logic       tx_irq
);
   localparam int AW = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1;

   if ((BUF_DEPTH & (BUF_DEPTH - 1)) != 0 || BUF_DEPTH < 2) begin : g_bad_depth
      $error("txdual_ctrl: BUF_DEPTH must be a power of two of at least 2");
   end
   if (BUF_DEPTH > 65536) begin : g_big_depth
      $error("txdual_ctrl: BUF_DEPTH must fit the 16-bit read pointer view");
   end

   logic [LEN_W-1:0]     len_q;
   logic [AW-1:0]        wptr_q;
   logic [NUM_SLOTS-1:0] done_q;
   logic                 ovr_q;
   logic                 irq_q;

   logic             wr_status, wr_irq, wr_fifo, poll, push;
   logic             head_valid, head_idx, full, any_busy, fin;
   logic [AW-1:0]    head_start, rd_addr, push_start;
   logic [LEN_W-1:0] head_len;
   logic [7:0]       rd_byte;
   logic [15:0]      rptr16;

   assign wr_status  = host_wr && host_addr == RA_STATUS;
   assign wr_irq     = host_wr && host_addr == RA_IRQ;
   assign wr_fifo    = host_wr && host_addr == RA_FIFO;
   assign poll       = host_wr && host_addr == RA_CMD && host_wdata[CMD_POLL];
   assign push       = poll && !full && (len_q != '0);
   assign push_start = wptr_q - len_q[AW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q  <= '0;
         wptr_q <= '0;
      end else begin
         if (host_wr && host_addr == RA_LEN_LO) len_q[7:0]  <= host_wdata;
         if (host_wr && host_addr == RA_LEN_HI) len_q[15:8] <= host_wdata;
         if (wr_fifo) wptr_q <= wptr_q + 1'b1;
      end
   end

   // per-slot sticky completion flags, set wins over a same-cycle clear
   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_done
      localparam int BITPOS = (i == 0) ? ST_DONE0 : ST_DONE1;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                             done_q[i] <= 1'b0;
         else if (fin && head_idx == 1'(i))      done_q[i] <= 1'b1;
         else if (wr_status && host_wdata[BITPOS]) done_q[i] <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovr_q <= 1'b0;
         irq_q <= 1'b0;
      end else begin
         if (poll && full)                         ovr_q <= 1'b1;
         else if (wr_status && host_wdata[ST_OVR]) ovr_q <= 1'b0;
         if (fin)                                  irq_q <= 1'b1;
         else if (wr_irq && host_wdata[IRQ_TX])    irq_q <= 1'b0;
      end
   end

   txdual_buf #(.DEPTH(BUF_DEPTH), .AW(AW)) buf_i (
      .clk     (clk),
      .wr_en   (wr_fifo),
      .wr_addr (wptr_q),
      .wr_data (host_wdata),
      .rd_addr (rd_addr),
      .rd_data (rd_byte)
   );

   txdual_slots #(.AW(AW)) slots_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (push),
      .push_start (push_start),
      .push_len   (len_q),
      .pop        (fin),
      .head_valid (head_valid),
      .head_idx   (head_idx),
      .head_start (head_start),
      .head_len   (head_len),
      .full       (full),
      .any_busy   (any_busy)
   );

   txdual_sender #(.AW(AW)) sender_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .head_valid (head_valid),
      .head_start (head_start),
      .head_len   (head_len),
      .rd_addr    (rd_addr),
      .rd_data    (rd_byte),
      .tx_data    (tx_data),
      .tx_valid   (tx_valid),
      .tx_last    (tx_last),
      .tx_ready   (tx_ready),
      .done_pulse (fin)
   );

   assign rptr16 = 16'(rd_addr);
   assign tx_irq = irq_q;

   always_comb begin
      host_rdata = '0;
      unique case (host_addr)
         RA_STATUS: begin
            host_rdata[ST_DONE0] = done_q[0];
            host_rdata[ST_DONE1] = done_q[1];
            host_rdata[ST_OVR]   = ovr_q;
         end
         RA_CMD:     host_rdata[CMD_POLL] = any_busy;
         RA_LEN_LO:  host_rdata = len_q[7:0];
         RA_LEN_HI:  host_rdata = len_q[15:8];
         RA_IRQ:     host_rdata[IRQ_TX] = irq_q;
         RA_RPTR_LO: host_rdata = rptr16[7:0];
         RA_RPTR_HI: host_rdata = rptr16[15:8];
         default:    host_rdata = '0;
      endcase
   end

   a_r3_busy_after_push: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> any_busy);
   a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q[0] && !(wr_status && host_wdata[ST_DONE0])) |=> done_q[0]);
   a_r7_irq_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> tx_irq);
   a_r8_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (poll && full) |=> ovr_q);
   a_r6_one_done_per_finish: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> $countones(done_q & ~$past(done_q)) <= 1);
endmodule

// File: tb/txdual_ctrl_tb_top.sv
module txdual_ctrl_tb_top;
   localparam int D = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_wr = 1'b0;
   logic [7:0] host_addr = 8'h01;
   logic [7:0] host_wdata = 8'h00;
   logic [7:0] host_rdata;
   logic [7:0] tx_data;
   logic       tx_valid, tx_last, tx_irq;
   logic       tx_ready = 1'b1;

   always #2 clk = ~clk;   // 250 MHz

   txdual_ctrl #(.BUF_DEPTH(D)) dut_i (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .tx_data(tx_data),
      .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready), .tx_irq(tx_irq)
   );

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   int seen_frames = 0;
   bit started = 0;
   int rd_idx = 0;
   int ready_mode = 0;
   logic [15:0] lfsr = 16'hACE1;

   // reference model state
   byte unsigned m_mem [D];
   int  m_wptr, m_rptr, m_len, m_off;
   bit  m_sending, m_irq, m_ovr;
   bit  m_done [2];
   int  m_q_slot[$], m_q_start[$], m_q_len[$];

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   function automatic logic [7:0] rd_list(input int k);
      case (k)
         0: return 8'h01;
         1: return 8'h02;
         2: return 8'h04;
         3: return 8'h05;
         4: return 8'h06;
         5: return 8'h0A;
         default: return 8'h0B;
      endcase
   endfunction

   function automatic string tag_of(input logic [7:0] a);
      case (a)
         8'h01: return "R6 status read";
         8'h02: return "R3 command read";
         8'h04, 8'h05: return "R1 length read";
         8'h06: return "R7 irq read";
         8'h0A, 8'h0B: return "R10 read pointer";
         default: return "R2 other read";
      endcase
   endfunction

   function automatic int exp_read(input logic [7:0] a);
      case (a)
         8'h01: return (int'(m_ovr) << 4) | (int'(m_done[1]) << 3) | (int'(m_done[0]) << 2);
         8'h02: return (m_q_len.size() != 0) ? 1 : 0;
         8'h04: return m_len & 8'hFF;
         8'h05: return (m_len >> 8) & 8'hFF;
         8'h06: return int'(m_irq) << 1;
         8'h0A: return m_rptr & 8'hFF;
         8'h0B: return (m_rptr >> 8) & 8'hFF;
         default: return 0;
      endcase
   endfunction

   // model: steps on every edge from the inputs presented before it
   always @(posedge clk) begin
      if (!rst_n) begin
         m_wptr = 0; m_rptr = 0; m_len = 0; m_off = 0;
         m_sending = 0; m_irq = 0; m_ovr = 0; m_done[0] = 0; m_done[1] = 0;
         m_q_slot.delete(); m_q_start.delete(); m_q_len.delete();
      end else begin
         int  pre_n, pre_front, pre_len, pre_wptr;
         bit  acc, fin, poll, pre_send;
         cycles++;
         if (cycles > 50000) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
         end
         pre_n     = m_q_len.size();
         pre_front = (pre_n > 0) ? m_q_slot[0] : 0;
         pre_len   = m_len;
         pre_wptr  = m_wptr;
         pre_send  = m_sending;
         acc  = m_sending && tx_ready;
         fin  = acc && (m_off == m_q_len[0] - 1);
         poll = host_wr && host_addr == 8'h02 && host_wdata[0];
         if (host_wr && host_addr == 8'h01) begin
            if (host_wdata[2]) m_done[0] = 0;
            if (host_wdata[3]) m_done[1] = 0;
            if (host_wdata[4]) m_ovr = 0;
         end
         if (host_wr && host_addr == 8'h06 && host_wdata[1]) m_irq = 0;
         if (host_wr && host_addr == 8'h04) m_len = (m_len & 16'hFF00) | host_wdata;
         if (host_wr && host_addr == 8'h05) m_len = (m_len & 16'h00FF) | (int'(host_wdata) << 8);
         if (host_wr && host_addr == 8'h08) begin
            m_mem[m_wptr] = host_wdata;
            m_wptr = (m_wptr + 1) % D;
         end
         if (acc) begin
            m_off++;
            m_rptr = (m_rptr + 1) % D;
         end
         if (fin) begin
            m_done[m_q_slot[0]] = 1;
            m_irq = 1;
            void'(m_q_slot.pop_front()); void'(m_q_start.pop_front()); void'(m_q_len.pop_front());
            m_sending = 0;
         end else if (!pre_send && pre_n > 0) begin
            m_sending = 1;
            m_off = 0;
            m_rptr = m_q_start[0];
         end
         if (poll) begin
            if (pre_n == 2) m_ovr = 1;
            else if (pre_len != 0) begin
               m_q_slot.push_back((pre_n == 0) ? 0 : 1 - pre_front);
               m_q_start.push_back(((pre_wptr - pre_len) % D + D) % D);
               m_q_len.push_back(pre_len);
            end
         end
      end
   end

   // compare mid-cycle
   always @(negedge clk) begin
      if (rst_n && started) begin
         chk("R4 tx_valid", tx_valid, m_sending);
         if (m_sending) begin
            chk("R2 tx_data", tx_data, m_mem[(m_q_start[0] + m_off) % D]);
            chk("R5 tx_last", tx_last, (m_off == m_q_len[0] - 1) ? 1 : 0);
         end
         chk("R7 tx_irq", tx_irq, m_irq);
         chk(tag_of(host_addr), host_rdata, exp_read(host_addr));
         if (tx_valid && tx_ready && tx_last) seen_frames++;
      end
   end

   // downstream ready pattern
   initial begin
      forever begin
         @(posedge clk); #1;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         tx_ready = (ready_mode == 0) ? 1'b1 : (lfsr[0] | lfsr[3]);
      end
   end

   task automatic step();
      @(posedge clk); #1;
      host_wr = 1'b0;
      host_addr = rd_list(rd_idx);
      rd_idx = (rd_idx + 1) % 7;
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      step();
   endtask

   task automatic load(input int len, input int seed);
      wr(8'h04, len[7:0]);
      wr(8'h05, len[15:8]);
      for (int i = 0; i < len; i++) wr(8'h08, 8'(seed + 7 * i));
   endtask

   task automatic drain();
      int lim = 0;
      while ((m_q_len.size() != 0 || m_sending) && lim < 5000) begin
         step(); lim++;
      end
      repeat (4) step();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R11: reset state at the ports
      chk("R11 reset tx_valid", tx_valid, 0);
      chk("R11 reset tx_irq", tx_irq, 0);
      chk("R11 reset status", host_rdata, 0);
      started = 1;
      step();

      // single frame, ready always high
      load(5, 8'h10);
      wr(8'h02, 8'h01);
      drain();

      // two frames, second queued while first sends, stalling downstream
      ready_mode = 1;
      load(20, 8'h40);
      wr(8'h02, 8'h01);
      load(6, 8'h90);
      wr(8'h02, 8'h01);
      drain();
      chk("R4 frames after pair", seen_frames, 3);

      // overrun: third poll while both slots are taken
      load(30, 8'h21);
      wr(8'h02, 8'h01);
      load(4, 8'hC3);
      wr(8'h02, 8'h01);
      wr(8'h02, 8'h01);
      drain();
      chk("R8 overrun frame count", seen_frames, 5);

      // zero-length poll
      ready_mode = 0;
      wr(8'h04, 8'h00);
      wr(8'h05, 8'h00);
      wr(8'h02, 8'h01);
      repeat (10) step();
      chk("R9 zero length sends nothing", seen_frames, 5);

      // write-one-to-clear flags
      wr(8'h01, 8'h1C);
      wr(8'h06, 8'h02);
      repeat (8) step();
      chk("R7 irq cleared", tx_irq, 0);

      finish_run();
   end
endmodule